// File: doc/BRIEF.md
# Exception Control Register Bank

This block holds the control registers that a small 32-bit RISC core keeps for exception handling. There are four of them: the status register, the cause register, the saved return address and the faulting-address register. When the pipeline raises an exception, the block records the exception state in hardware in one clock edge. It saves the address of the interrupted instruction, stores the exception code, captures a bad data address when there is one, and enters exception level. A return-from-exception strobe leaves exception level.

Software reaches the registers only through a transfer port driven by the core's coprocessor move instructions. A move-to replaces a whole register. A move-from returns the selected register combinationally on the read bus. Single fields are therefore changed by reading the register, modifying the value in a core register and writing it back. Each register sits at a fixed index. Indices that hold no register read as zero and absorb writes.

The pipeline uses three outputs. The saved return address is used when the handler returns. An interrupt-enable level tells the pipeline whether interrupts may be taken. A pending flag reports that an exception is being handled.

Top module: `exc_ctl_regs`

## Requirements
- R1: After reset, the registers at indices 8, 12, 13 and 14 all read zero, `int_en_o` is 0 and `exc_pending_o` is 0.
- R2: A move-to at index 12 (status), 14 (return address) or 8 (faulting address) stores all 32 bits of `rf_wdata` at the clock edge, and a later move-from at that index returns exactly those bits on `rf_rdata`.
- R3: The cause register at index 13 keeps only bits 6:2, the exception-code field. A move-to there stores `rf_wdata[6:2]`, and a move-from returns those bits with every other bit zero.
- R4: On a clock edge with `exc_valid` high, the return-address register (index 14, also shown on `epc_o`) loads `exc_pc`.
- R5: On a clock edge with `exc_valid` high, the cause register loads `exc_code` into bits 6:2 and clears all its other bits.
- R6: On an exception edge, the faulting-address register loads `exc_badaddr` only when `exc_badaddr_vld` is high. Otherwise it keeps its value.
- R7: Status bit 1 is the exception-level flag. An exception edge sets it, and an `eret` edge without an exception clears it. Neither event changes any other status bit.
- R8: `int_en_o` is high exactly when status bit 0 is 1 and status bit 1 is 0. `exc_pending_o` equals status bit 1.
- R9: If a hardware capture and a move-to hit the same register on the same edge, the captured value wins for each field the capture loads. The rest of the written value still lands. If `exc_valid` and `eret` arrive together, the exception-level flag ends up set.
- R10: A move-from at any index other than 8, 12, 13 and 14 returns zero. A move-to at such an index changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_valid | input | 1 | Exception capture strobe |
| exc_code | input | 5 | Exception code to record |
| exc_pc | input | 32 | Address of the interrupted instruction |
| exc_badaddr_vld | input | 1 | Exception carries a faulting data address |
| exc_badaddr | input | 32 | Faulting data address |
| eret | input | 1 | Return-from-exception strobe |
| rf_idx | input | 5 | Register index for a move-to or move-from |
| rf_we | input | 1 | Move-to write enable |
| rf_wdata | input | 32 | Move-to data |
| rf_rdata | output | 32 | Move-from data for `rf_idx` |
| epc_o | output | 32 | Saved exception return address |
| int_en_o | output | 1 | Interrupts may be taken |
| exc_pending_o | output | 1 | Exception level active |

## Verification
The bench writes distinct patterns to all 32 indices and reads every index back. This exposes a decoder that aliases an unimplemented index onto a real register, a cause register that keeps bits outside its code field, and a status write that drops bits. All 32 exception codes are driven, with the faulting-address flag alternating. A design that updates the faulting address unconditionally, places the code at the wrong bit offset, or loses the enable bit when exception level is set would fail here. Same-edge collisions are covered for each register: move-to against capture, and exception against return. A design that lets software win or lets the return clear a fresh exception level would show the wrong value on the next read.

// File: rtl/exc_pkg.sv
package exc_pkg;

    typedef enum logic [2:0] {
        SEL_NONE    = 3'd0,
        SEL_STATUS  = 3'd1,
        SEL_CAUSE   = 3'd2,
        SEL_EPC     = 3'd3,
        SEL_BADADDR = 3'd4
    } reg_sel_e;

endpackage

// File: rtl/exc_idx_decode.sv
module exc_idx_decode
    import exc_pkg::*;
#(
    parameter int IDX_W       = 5,
    parameter int IDX_STATUS  = 12,
    parameter int IDX_CAUSE   = 13,
    parameter int IDX_EPC     = 14,
    parameter int IDX_BADADDR = 8
) (
    input  logic [IDX_W-1:0] idx,
    output reg_sel_e         sel
);

    always_comb begin
        if (idx == IDX_W'(IDX_STATUS))       sel = SEL_STATUS;
        else if (idx == IDX_W'(IDX_CAUSE))   sel = SEL_CAUSE;
        else if (idx == IDX_W'(IDX_EPC))     sel = SEL_EPC;
        else if (idx == IDX_W'(IDX_BADADDR)) sel = SEL_BADADDR;
        else                                 sel = SEL_NONE;
    end

endmodule

// File: rtl/exc_reg_core.sv
module exc_reg_core
    import exc_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int CODE_W   = 5,
    parameter int CODE_LSB = 2,
    parameter int IE_BIT   = 0,
    parameter int EXL_BIT  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_valid,
    input  logic [CODE_W-1:0] exc_code,
    input  logic [XLEN-1:0]   exc_pc,
    input  logic              exc_badaddr_vld,
    input  logic [XLEN-1:0]   exc_badaddr,
    input  logic              eret,
    input  logic              wr_en,
    input  reg_sel_e          wr_sel,
    input  logic [XLEN-1:0]   wr_data,
    output logic [XLEN-1:0]   status_q,
    output logic [XLEN-1:0]   cause_q,
    output logic [XLEN-1:0]   epc_q,
    output logic [XLEN-1:0]   badaddr_q
);

    localparam logic [XLEN-1:0] CAUSE_MASK =
        {{(XLEN-CODE_W){1'b0}}, {CODE_W{1'b1}}} << CODE_LSB;

    typedef struct packed {
        logic [XLEN-1:0] status;
        logic [XLEN-1:0] cause;
        logic [XLEN-1:0] epc;
        logic [XLEN-1:0] badaddr;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // software transfer first, so hardware capture overrides it below
        if (wr_en) begin
            case (wr_sel)
                SEL_STATUS:  st_d.status  = wr_data;
                SEL_CAUSE:   st_d.cause   = wr_data & CAUSE_MASK;
                SEL_EPC:     st_d.epc     = wr_data;
                SEL_BADADDR: st_d.badaddr = wr_data;
                default:     ;
            endcase
        end
        if (eret) begin
            st_d.status[EXL_BIT] = 1'b0;
        end
        if (exc_valid) begin
            st_d.epc                       = exc_pc;
            st_d.cause                     = '0;
            st_d.cause[CODE_LSB +: CODE_W] = exc_code;
            st_d.status[EXL_BIT]           = 1'b1;
            if (exc_badaddr_vld) begin
                st_d.badaddr = exc_badaddr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_q  = st_q.status;
    assign cause_q   = st_q.cause;
    assign epc_q     = st_q.epc;
    assign badaddr_q = st_q.badaddr;

    // R4
    epc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> (epc_q == $past(exc_pc)));

    // R5
    cause_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> (cause_q == ($past({{(XLEN-CODE_W){1'b0}}, exc_code}) << CODE_LSB)));

    // R6
    badaddr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(exc_valid && exc_badaddr_vld) && !(wr_en && wr_sel == SEL_BADADDR))
        |=> $stable(badaddr_q));

    // R7
    exl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> status_q[EXL_BIT]);

    // R7
    exl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eret && !exc_valid) |=> !status_q[EXL_BIT]);

    // R3
    cause_field_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_q & ~CAUSE_MASK) == '0);

endmodule

// File: rtl/exc_read_mux.sv
module exc_read_mux
    import exc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  reg_sel_e        sel,
    input  logic [XLEN-1:0] status_q,
    input  logic [XLEN-1:0] cause_q,
    input  logic [XLEN-1:0] epc_q,
    input  logic [XLEN-1:0] badaddr_q,
    output logic [XLEN-1:0] rdata
);

    always_comb begin
        case (sel)
            SEL_STATUS:  rdata = status_q;
            SEL_CAUSE:   rdata = cause_q;
            SEL_EPC:     rdata = epc_q;
            SEL_BADADDR: rdata = badaddr_q;
            default:     rdata = '0;
        endcase
    end

endmodule

// File: rtl/exc_ctl_regs.sv
module exc_ctl_regs
    import exc_pkg::*;
#(
    parameter int XLEN        = 32,
    parameter int IDX_W       = 5,
    parameter int CODE_W      = 5,
    parameter int CODE_LSB    = 2,
    parameter int IE_BIT      = 0,
    parameter int EXL_BIT     = 1,
    parameter int IDX_STATUS  = 12,
    parameter int IDX_CAUSE   = 13,
    parameter int IDX_EPC     = 14,
    parameter int IDX_BADADDR = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_valid,
    input  logic [CODE_W-1:0] exc_code,
    input  logic [XLEN-1:0]   exc_pc,
    input  logic              exc_badaddr_vld,
    input  logic [XLEN-1:0]   exc_badaddr,
    input  logic              eret,
    input  logic [IDX_W-1:0]  rf_idx,
    input  logic              rf_we,
    input  logic [XLEN-1:0]   rf_wdata,
    output logic [XLEN-1:0]   rf_rdata,
    output logic [XLEN-1:0]   epc_o,
    output logic              int_en_o,
    output logic              exc_pending_o
);

    reg_sel_e        sel;
    logic [XLEN-1:0] status_q, cause_q, epc_q, badaddr_q;

    exc_idx_decode #(
        .IDX_W(IDX_W), .IDX_STATUS(IDX_STATUS), .IDX_CAUSE(IDX_CAUSE),
        .IDX_EPC(IDX_EPC), .IDX_BADADDR(IDX_BADADDR)
    ) u_decode (
        .idx (rf_idx),
        .sel (sel)
    );

    exc_reg_core #(
        .XLEN(XLEN), .CODE_W(CODE_W), .CODE_LSB(CODE_LSB),
        .IE_BIT(IE_BIT), .EXL_BIT(EXL_BIT)
    ) u_core (
        .clk             (clk),
        .rst_n           (rst_n),
        .exc_valid       (exc_valid),
        .exc_code        (exc_code),
        .exc_pc          (exc_pc),
        .exc_badaddr_vld (exc_badaddr_vld),
        .exc_badaddr     (exc_badaddr),
        .eret            (eret),
        .wr_en           (rf_we),
        .wr_sel          (sel),
        .wr_data         (rf_wdata),
        .status_q        (status_q),
        .cause_q         (cause_q),
        .epc_q           (epc_q),
        .badaddr_q       (badaddr_q)
    );

    exc_read_mux #(.XLEN(XLEN)) u_rmux (
        .sel       (sel),
        .status_q  (status_q),
        .cause_q   (cause_q),
        .epc_q     (epc_q),
        .badaddr_q (badaddr_q),
        .rdata     (rf_rdata)
    );

    assign epc_o         = epc_q;
    assign int_en_o      = status_q[IE_BIT] & ~status_q[EXL_BIT];
    assign exc_pending_o = status_q[EXL_BIT];

    // R8
    int_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_en_o |-> !exc_pending_o);

    // R10
    unimpl_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_idx != IDX_W'(IDX_STATUS) && rf_idx != IDX_W'(IDX_CAUSE) &&
         rf_idx != IDX_W'(IDX_EPC) && rf_idx != IDX_W'(IDX_BADADDR))
        |-> (rf_rdata == '0));

    // R9
    eret_loses_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && eret) |=> exc_pending_o);

endmodule

// File: tb/exc_ctl_regs_bench.sv
module exc_ctl_regs_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        exc_valid;
    logic [4:0]  exc_code;
    logic [31:0] exc_pc;
    logic        exc_badaddr_vld;
    logic [31:0] exc_badaddr;
    logic        eret;
    logic [4:0]  rf_idx;
    logic        rf_we;
    logic [31:0] rf_wdata;
    logic [31:0] rf_rdata;
    logic [31:0] epc_o;
    logic        int_en_o;
    logic        exc_pending_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    exc_ctl_regs u_exc_ctl_regs (
        .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_code(exc_code),
        .exc_pc(exc_pc), .exc_badaddr_vld(exc_badaddr_vld), .exc_badaddr(exc_badaddr),
        .eret(eret), .rf_idx(rf_idx), .rf_we(rf_we), .rf_wdata(rf_wdata),
        .rf_rdata(rf_rdata), .epc_o(epc_o), .int_en_o(int_en_o),
        .exc_pending_o(exc_pending_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one clock edge with whatever is driven, then idle the strobes
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        exc_valid = 1'b0; eret = 1'b0; rf_we = 1'b0; exc_badaddr_vld = 1'b0;
    endtask

    task automatic wr(input logic [4:0] idx, input logic [31:0] d);
        rf_idx = idx; rf_wdata = d; rf_we = 1'b1;
        step();
    endtask

    task automatic rd(input logic [4:0] idx, output logic [31:0] d);
        rf_idx = idx;
        #1;
        d = rf_rdata;
    endtask

    function automatic logic [31:0] pat(input int i, input logic [31:0] salt);
        return (32'h0101_0101 * i) ^ salt ^ {i[7:0], 24'h5A3C96};
    endfunction

    function automatic logic [31:0] exp_read(input int i, input logic [31:0] salt);
        if (i == 8 || i == 12 || i == 14) return pat(i, salt);
        if (i == 13) return pat(i, salt) & 32'h0000_007C;
        return 32'h0;
    endfunction

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r, last_bad, st;
        rst_n = 1'b0; exc_valid = 1'b0; exc_code = '0; exc_pc = '0;
        exc_badaddr_vld = 1'b0; exc_badaddr = '0; eret = 1'b0;
        rf_idx = '0; rf_we = 1'b0; rf_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(5'd8, r);  check("R1 badaddr", r, 0);
        rd(5'd12, r); check("R1 status", r, 0);
        rd(5'd13, r); check("R1 cause", r, 0);
        rd(5'd14, r); check("R1 epc", r, 0);
        check("R1 int_en", {31'b0, int_en_o}, 0);
        check("R1 pending", {31'b0, exc_pending_o}, 0);

        // R2 R3 R10 sweep of every index with two salts
        for (int s = 0; s < 2; s++) begin
            logic [31:0] salt;
            salt = (s == 0) ? 32'h0 : 32'hFFFF_FFFF;
            for (int i = 0; i < 32; i++) wr(i[4:0], pat(i, salt));
            for (int i = 0; i < 32; i++) begin
                rd(i[4:0], r);
                check((i == 13) ? "R3 cause readback" :
                      (i == 8 || i == 12 || i == 14) ? "R2 readback" : "R10 unimpl",
                      r, exp_read(i, salt));
            end
            st = pat(12, salt);
            check("R8 int_en after write", {31'b0, int_en_o}, {31'b0, st[0] & ~st[1]});
            check("R8 pending after write", {31'b0, exc_pending_o}, {31'b0, st[1]});
        end

        // R10 writes to unimplemented indices leave the real registers alone
        wr(5'd8, 32'h1111_1111); wr(5'd12, 32'h0); wr(5'd13, 32'h7C); wr(5'd14, 32'h2222_2222);
        for (int i = 0; i < 32; i++)
            if (i != 8 && i != 12 && i != 13 && i != 14) wr(i[4:0], 32'hFFFF_FFFF);
        rd(5'd8, r);  check("R10 badaddr kept", r, 32'h1111_1111);
        rd(5'd12, r); check("R10 status kept", r, 32'h0);
        rd(5'd13, r); check("R10 cause kept", r, 32'h7C);
        rd(5'd14, r); check("R10 epc kept", r, 32'h2222_2222);

        // R4 R5 R6 R7 R8 exception sweep over all codes
        wr(5'd12, 32'h0000_0F01);
        check("R8 int_en enabled", {31'b0, int_en_o}, 1);
        last_bad = 32'h1111_1111;
        for (int c = 0; c < 32; c++) begin
            exc_valid = 1'b1; exc_code = c[4:0]; exc_pc = 32'h0040_1000 + c * 4;
            exc_badaddr_vld = c[0]; exc_badaddr = 32'hBAD0_0000 + c;
            if (c[0]) last_bad = 32'hBAD0_0000 + c;
            step();
            check("R4 epc_o", epc_o, 32'h0040_1000 + c * 4);
            rd(5'd14, r); check("R4 epc read", r, 32'h0040_1000 + c * 4);
            rd(5'd13, r); check("R5 cause", r, c << 2);
            rd(5'd8, r);  check("R6 badaddr", r, last_bad);
            rd(5'd12, r); check("R7 status exl set", r, 32'h0000_0F03);
            check("R8 int_en masked", {31'b0, int_en_o}, 0);
            check("R8 pending", {31'b0, exc_pending_o}, 1);
            eret = 1'b1;
            step();
            rd(5'd12, r); check("R7 status after eret", r, 32'h0000_0F01);
            check("R8 int_en restored", {31'b0, int_en_o}, 1);
            check("R8 pending cleared", {31'b0, exc_pending_o}, 0);
        end

        // R9 collisions
        exc_valid = 1'b1; exc_code = 5'd9; exc_pc = 32'hCAFE_0000;
        rf_idx = 5'd14; rf_wdata = 32'h1234_5678; rf_we = 1'b1;
        step();
        rd(5'd14, r); check("R9 epc capture wins", r, 32'hCAFE_0000);

        exc_valid = 1'b1; exc_code = 5'd3; exc_pc = 32'h0;
        rf_idx = 5'd13; rf_wdata = 32'h0000_007C; rf_we = 1'b1;
        step();
        rd(5'd13, r); check("R9 cause capture wins", r, 32'h0000_000C);

        exc_valid = 1'b1; exc_badaddr_vld = 1'b1; exc_badaddr = 32'hDEAD_BEEF;
        rf_idx = 5'd8; rf_wdata = 32'h0BAD_F00D; rf_we = 1'b1;
        step();
        rd(5'd8, r); check("R9 badaddr capture wins", r, 32'hDEAD_BEEF);

        exc_valid = 1'b1; exc_badaddr_vld = 1'b0;
        rf_idx = 5'd8; rf_wdata = 32'h0BAD_F00D; rf_we = 1'b1;
        step();
        rd(5'd8, r); check("R9 R6 badaddr write lands without flag", r, 32'h0BAD_F00D);

        exc_valid = 1'b1; rf_idx = 5'd12; rf_wdata = 32'h0000_0000; rf_we = 1'b1;
        step();
        rd(5'd12, r); check("R9 status exl forced", r, 32'h0000_0002);

        wr(5'd12, 32'h0000_0001);
        exc_valid = 1'b1; eret = 1'b1;
        step();
        check("R9 exc beats eret", {31'b0, exc_pending_o}, 1);

        eret = 1'b1; rf_idx = 5'd12; rf_wdata = 32'hFFFF_FFFF; rf_we = 1'b1;
        step();
        rd(5'd12, r); check("R7 eret with status write", r, 32'hFFFF_FFFD);
        check("R8 int_en after eret write", {31'b0, int_en_o}, 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule